// File: doc/BRIEF.md
# Fixed-Point Systolic Matrix Multiplier (4x4, Q5.10)

This block multiplies two square matrices of signed Q5.10 fixed-point numbers (16-bit two's complement, 10 fractional bits) on a grid of processing cells, one cell per result element. A host places both operand matrices on flat packed input buses and pulses `start`. The block captures both operands on that edge and raises `busy`. It then feeds matrix rows into the left edge of the grid and matrix columns into the top edge, delaying each lane by its index. On every step, each cell multiplies the pair of operands it holds, scales the product back to Q5.10, adds it to its own accumulator and passes its operands on to the cell to its right and the cell below.

With a grid size of N, the run lasts 3N-2 cycles, which is 10 cycles at the default size. At the end of the run the block pulses `done` for one cycle, lowers `busy` and presents the product on `c_flat`. The result and the cycle count stay on the outputs until the next accepted start. The host may change the operand buses freely during a run.

Top module: `systolic_q510_mm`

## Requirements
- R1: After a synchronous reset, `busy` is 0, `done` is 0, `cycle_count` is 0 and `c_flat` is all zeros.
- R2: A `start` sampled while `busy` is 0 captures `a_flat` and `b_flat`. In the cycle after that edge, `busy` is 1 and `cycle_count` is 0. Changes on `a_flat` or `b_flat` after the capture edge do not affect the result.
- R3: `done` is a pulse one cycle wide. It rises exactly 10 (3N-2) clock edges after the capture edge. `busy` falls on the same edge that `done` rises, and `cycle_count` reads 10 while `done` is high.
- R4: While `busy` is high, `cycle_count` goes up by one on every edge. While the block is idle and no start is accepted, `cycle_count` keeps its value.
- R5: Element (r,c) occupies bits [(r*N+c)*16 +: 16] of its bus, and A and B use the same packing. When `done` is seen, C[r][c] equals the sum over k of (A[r][k]*B[k][c]) >>> 10, truncated to its low 16 bits. For example, with B equal to the identity matrix (1.0 = raw 1024 on the diagonal), C equals A.
- R6: Each 32-bit product is shifted right arithmetically, so negative values round toward minus infinity. With every raw A element at -1 and every raw B element at 1, each C element is raw -4 (0xFFFC).
- R7: The block does not saturate. When every raw element of A and B is 0x7FFF, each C element wraps to 0xFF00.
- R8: A `start` sampled while `busy` is 1 is ignored. The run continues with its original operands and its original timing.
- R9: After `done`, `c_flat` holds its value until the next accepted start. That start clears every accumulator, so consecutive runs do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication. Accepted only while idle |
| a_flat | input | N*N*16 | Matrix A, row-major packed |
| b_flat | input | N*N*16 | Matrix B, row-major packed |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| cycle_count | output | CNT_W | Cycles counted since the last accepted start |
| c_flat | output | N*N*16 | Result matrix C, row-major packed |

## Verification
The assertions watch the control behaviour on every cycle. They check the shape of the `done` pulse and that `busy` falls together with it, that a start accepted while idle sets `busy` and clears the count, that the count advances during a run and holds while idle, that a start during a run does not restart it, and that `c_flat` stays put while idle. The arithmetic can only be shown by the bench scenarios, which compare `c_flat` against an independent model. These cover the identity matrix, mixed signs, rounding toward minus infinity, wraparound, operand changes during a run and consecutive runs. Only those scenarios confirm that the skewed feed lines up the right A and B elements in every cell.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // bit offset of element (row, col) inside a row-major packed square matrix
  function automatic int elem_lsb(input int row, input int col, input int n, input int w);
    return (row * n + col) * w;
  endfunction

endpackage

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl #(
  parameter int N      = 4,
  parameter int CNT_W  = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              launch,
  output logic              run,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  cycle_count
);
  import sysmm_pkg::*;

  localparam int LAST_STEP = 3 * N - 3;

  phase_t phase_q;

  assign launch = start && (phase_q == PH_IDLE);
  assign run    = (phase_q == PH_RUN);
  assign busy   = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      done        <= 1'b0;
      step        <= '0;
      cycle_count <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        phase_q     <= PH_RUN;
        step        <= '0;
        cycle_count <= '0;
      end else if (run) begin
        step        <= step + 1'b1;
        cycle_count <= cycle_count + 1'b1;
        if (step == STEP_W'(LAST_STEP)) begin
          phase_q <= PH_IDLE;
          done    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sysmm_feed.sv
module sysmm_feed #(
  parameter int N      = 4,
  parameter int W      = 16,
  parameter int STEP_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                run,
  input  logic [STEP_W-1:0]   step,
  input  logic [N*N*W-1:0]    a_flat,
  input  logic [N*N*W-1:0]    b_flat,
  output logic [N*W-1:0]      row_inject_flat,
  output logic [N*W-1:0]      col_inject_flat
);
  import sysmm_pkg::*;

  logic [N*N*W-1:0] a_q;
  logic [N*N*W-1:0] b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_flat;
      b_q <= b_flat;
    end
  end

  // lane i carries the element whose inner index k satisfies step == i + k
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [W-1:0] row_sel;
    logic [W-1:0] col_sel;

    always_comb begin
      row_sel = '0;
      col_sel = '0;
      if (run) begin
        for (int k = 0; k < N; k++) begin
          if (int'(step) == i + k) begin
            row_sel = a_q[elem_lsb(i, k, N, W) +: W];
            col_sel = b_q[elem_lsb(k, i, N, W) +: W];
          end
        end
      end
    end

    assign row_inject_flat[i*W +: W] = row_sel;
    assign col_inject_flat[i*W +: W] = col_sel;
  end

endmodule

// File: rtl/sysmm_pe.sv
module sysmm_pe #(
  parameter int W     = 16,
  parameter int FRAC  = 10,
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [W-1:0]     x_in,
  input  logic signed [W-1:0]     y_in,
  output logic signed [W-1:0]     x_out,
  output logic signed [W-1:0]     y_out,
  output logic signed [ACC_W-1:0] acc
);

  localparam int PW = 2 * W;

  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    scaled;
  logic signed [ACC_W-1:0] scaled_ext;

  assign prod       = x_in * y_in;
  assign scaled     = prod >>> FRAC;
  assign scaled_ext = {{(ACC_W-PW){scaled[PW-1]}}, scaled};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      x_out <= '0;
      y_out <= '0;
      acc   <= '0;
    end else if (en) begin
      x_out <= x_in;
      y_out <= y_in;
      acc   <= acc + scaled_ext;
    end
  end

endmodule

// File: rtl/sysmm_grid.sv
module sysmm_grid #(
  parameter int N     = 4,
  parameter int W     = 16,
  parameter int FRAC  = 10,
  parameter int ACC_W = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               en,
  input  logic [N*W-1:0]     row_inject_flat,
  input  logic [N*W-1:0]     col_inject_flat,
  output logic [N*N*W-1:0]   c_flat
);
  import sysmm_pkg::*;

  logic signed [W-1:0] x_w [N][N+1];
  logic signed [W-1:0] y_w [N+1][N];

  for (genvar r = 0; r < N; r++) begin : g_left
    assign x_w[r][0] = row_inject_flat[r*W +: W];
    logic unused_x_edge;
    assign unused_x_edge = ^x_w[r][N];
  end

  for (genvar c = 0; c < N; c++) begin : g_top
    assign y_w[0][c] = col_inject_flat[c*W +: W];
    logic unused_y_edge;
    assign unused_y_edge = ^y_w[N][c];
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [ACC_W-1:0] acc;
      logic unused_acc_hi;

      sysmm_pe #(
        .W    (W),
        .FRAC (FRAC),
        .ACC_W(ACC_W)
      ) u_pe (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .en   (en),
        .x_in (x_w[r][c]),
        .y_in (y_w[r][c]),
        .x_out(x_w[r][c+1]),
        .y_out(y_w[r+1][c]),
        .acc  (acc)
      );

      assign c_flat[elem_lsb(r, c, N, W) +: W] = acc[W-1:0];
      assign unused_acc_hi = ^acc[ACC_W-1:W];
    end
  end

endmodule

// File: rtl/systolic_q510_mm.sv
module systolic_q510_mm #(
  parameter int N     = 4,
  parameter int W     = 16,
  parameter int FRAC  = 10,
  parameter int ACC_W = 40,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [N*N*W-1:0]   a_flat,
  input  logic [N*N*W-1:0]   b_flat,
  output logic               busy,
  output logic               done,
  output logic [CNT_W-1:0]   cycle_count,
  output logic [N*N*W-1:0]   c_flat
);

  localparam int RUN_LEN = 3 * N - 2;
  localparam int STEP_W  = $clog2(RUN_LEN);

  logic              launch;
  logic              run;
  logic [STEP_W-1:0] step;
  logic [N*W-1:0]    row_inject_flat;
  logic [N*W-1:0]    col_inject_flat;

  sysmm_ctrl #(
    .N     (N),
    .CNT_W (CNT_W),
    .STEP_W(STEP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .launch     (launch),
    .run        (run),
    .step       (step),
    .busy       (busy),
    .done       (done),
    .cycle_count(cycle_count)
  );

  sysmm_feed #(
    .N     (N),
    .W     (W),
    .STEP_W(STEP_W)
  ) u_feed (
    .clk            (clk),
    .rst            (rst),
    .load           (launch),
    .run            (run),
    .step           (step),
    .a_flat         (a_flat),
    .b_flat         (b_flat),
    .row_inject_flat(row_inject_flat),
    .col_inject_flat(col_inject_flat)
  );

  sysmm_grid #(
    .N    (N),
    .W    (W),
    .FRAC (FRAC),
    .ACC_W(ACC_W)
  ) u_grid (
    .clk            (clk),
    .rst            (rst),
    .clr            (launch),
    .en             (run),
    .row_inject_flat(row_inject_flat),
    .col_inject_flat(col_inject_flat),
    .c_flat         (c_flat)
  );

endmodule

// File: rtl/sysmm_checker.sv
module sysmm_checker #(
  parameter int N     = 4,
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cycle_count,
  input logic [N*N*W-1:0] c_flat
);

  localparam int RUN_LEN = 3 * N - 2;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && cycle_count == '0));

  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && cycle_count == '0));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_low_at_done_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_len_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycle_count == CNT_W'(RUN_LEN)));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cycle_count == $past(cycle_count) + CNT_W'(1)));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(cycle_count));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (cycle_count != '0));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(c_flat));

endmodule

bind systolic_q510_mm sysmm_checker #(
  .N    (N),
  .W    (W),
  .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .cycle_count(cycle_count),
  .c_flat     (c_flat)
);

// File: tb/sim_systolic_q510_mm.sv
`timescale 1ns/1ps
module sim_systolic_q510_mm;

  localparam int N     = 4;
  localparam int W     = 16;
  localparam int CNT_W = 8;
  localparam int FW    = N * N * W;
  localparam int RUN   = 3 * N - 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [FW-1:0] a_in = '0;
  logic [FW-1:0] b_in = '0;
  logic          busy;
  logic          done;
  logic [CNT_W-1:0] cycle_count;
  logic [FW-1:0] c_flat;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  systolic_q510_mm u0 (
    .clk(clk), .rst(rst), .start(start), .a_flat(a_in), .b_flat(b_in),
    .busy(busy), .done(done), .cycle_count(cycle_count), .c_flat(c_flat)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] el(input logic [FW-1:0] m, input int r, input int c);
    return m[(r*N+c)*W +: W];
  endfunction

  function automatic logic [FW-1:0] model(input logic [FW-1:0] a, input logic [FW-1:0] b);
    logic [FW-1:0] res;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        int sum;
        sum = 0;
        for (int k = 0; k < N; k++) begin
          logic signed [W-1:0] av;
          logic signed [W-1:0] bv;
          int p;
          av = el(a, r, k);
          bv = el(b, k, c);
          p = av * bv;
          sum = sum + (p >>> 10);
        end
        res[(r*N+c)*W +: W] = sum[W-1:0];
      end
    end
    return res;
  endfunction

  function automatic logic [FW-1:0] fill(input int base, input int sr, input int sc);
    logic [FW-1:0] m;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int v;
        v = base + r * sr + c * sc;
        m[(r*N+c)*W +: W] = v[W-1:0];
      end
    return m;
  endfunction

  function automatic logic [FW-1:0] ident();
    logic [FW-1:0] m;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        m[(r*N+c)*W +: W] = (r == c) ? 16'd1024 : 16'd0;
    return m;
  endfunction

  task automatic cmp_c(input logic [FW-1:0] exp, input string req);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        chk(el(c_flat, r, c) == el(exp, r, c), req, el(c_flat, r, c), el(exp, r, c));
  endtask

  // one full run; disturb changes operands and raises start mid-run (R2, R8)
  task automatic run_mm(input logic [FW-1:0] a, input logic [FW-1:0] b,
                        input bit disturb, input string req);
    logic [FW-1:0] exp;
    exp = model(a, b);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(cycle_count == 0, "R2 count cleared", cycle_count, 0);
    if (disturb) begin
      a_in = ~a; b_in = fill(77, 5, -9);
    end
    for (int i = 1; i <= RUN; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(cycle_count == CNT_W'(i), "R4 count step", cycle_count, i);
      chk(done == (i == RUN), "R3 done timing", done, (i == RUN));
      chk(busy == (i < RUN), "R3 busy timing", busy, (i < RUN));
      if (disturb && i == 3) start = 1'b1;
      if (disturb && i == 4) start = 1'b0;
    end
    cmp_c(exp, req);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R3 done single cycle", done, 0);
    chk(cycle_count == CNT_W'(RUN), "R4 count holds", cycle_count, RUN);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(cycle_count == 0, "R1 count", cycle_count, 0);
    chk(c_flat == '0, "R1 c_flat", c_flat != '0, 0);
  endtask

  task automatic t_identity();
    logic [FW-1:0] a;
    a = fill(-2100, 1492, 373);
    run_mm(a, ident(), 1'b0, "R5 model identity");
    cmp_c(a, "R5 identity equals A");
  endtask

  task automatic t_mixed();
    run_mm(fill(-2100, 1492, 373), fill(1500, -1477, -633), 1'b0, "R5 mixed signs");
  endtask

  task automatic t_floor();
    run_mm(fill(-1, 0, 0), fill(1, 0, 0), 1'b0, "R6 model floor");
    cmp_c({(N*N){16'hFFFC}}, "R6 floor toward minus infinity");
  endtask

  task automatic t_wrap();
    run_mm({(N*N){16'h7FFF}}, {(N*N){16'h7FFF}}, 1'b0, "R7 model wrap");
    cmp_c({(N*N){16'hFF00}}, "R7 wraps without saturation");
  endtask

  task automatic t_disturb();
    run_mm(fill(900, -310, 45), fill(-2500, 222, 1111), 1'b1, "R2 R8 captured operands kept");
  endtask

  task automatic t_hold_and_rerun();
    logic [FW-1:0] held;
    run_mm(fill(300, 50, -70), fill(-400, 90, 30), 1'b0, "R9 first run");
    held = c_flat;
    @(negedge clk);
    a_in = fill(5000, 1, 1); b_in = fill(-5000, 2, 2);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(c_flat == held, "R9 result holds while idle", c_flat != held, 0);
    chk(cycle_count == CNT_W'(RUN), "R4 count holds while idle", cycle_count, RUN);
    run_mm(fill(-700, 13, 400), fill(250, -60, 80), 1'b0, "R9 second run cleared");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_identity();
    t_mixed();
    t_floor();
    t_wrap();
    t_disturb();
    t_hold_and_rerun();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule